// File: doc/BRIEF.md
# Saturating-Counter Cache Replacement Tracker

This block keeps recency state for a set-associative cache and names the way to evict on a miss. Each way of each set has a small saturating age counter. A high value means recently used, and zero means stale or empty. The tag and data arrays live elsewhere. The cache controller reports three kinds of event to this block: a hit on a way, a fill of a way after a miss, and an invalidation of a way. Each event carries a set index and a way number. The block updates that set's counters in the next clock edge.

For any set the controller picks, the block presents two things combinationally: the current counters and the replacement candidate. The number of counter states, `USTATES`, is fixed at elaboration and may be 2, 3 or 4. Hits and fills age the other ways by different rules:

- A hit only ages the ways that were younger than the hit way.
- A fill ages every way that is not already at zero.

Top module: `lru_sat_repl`

## Requirements
- R1: After reset every counter of every set is 0, so `victim_way` is 0 for any `query_set`.
- R2: A hit on way w of set s decrements, by one, each other way of s whose counter is greater than w's counter before the hit. Way w becomes `USTATES-1`. Ways whose counter is less than or equal to w's are unchanged.
- R3: A fill of way w of set s decrements by one each other way of s whose counter is nonzero. Way w becomes `USTATES-1`.
- R4: `victim_way` is the way of `query_set` with the smallest counter. When several ways share that smallest counter, the lowest-numbered of them is chosen. When no counter is below `USTATES-1`, way 0 is chosen.
- R5: Counters never exceed `USTATES-1`.
- R6: An invalidation of way w of set s sets that counter to 0 and leaves the other ways of s unchanged.
- R7: An event on one set leaves the counters of every other set unchanged.
- R8: In a cycle with no event strobe, no counter changes. At most one of `hit_en`, `fill_en`, `inv_en` may be high in a cycle. If more than one is high, fill takes precedence over hit, and hit takes precedence over invalidate.
- R9: Updates take effect at the clock edge that samples the event. `victim_way` and `set_ages` are combinational from `query_set` and the stored counters. In `set_ages`, the counter of way i sits at bits [i*AGE_W +: AGE_W], where AGE_W = $clog2(USTATES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_en | input | 1 | Hit event strobe |
| fill_en | input | 1 | Fill event strobe |
| inv_en | input | 1 | Invalidate event strobe |
| evt_set | input | SET_W | Set index of the event |
| evt_way | input | WAY_W | Way number of the event |
| query_set | input | SET_W | Set whose state is presented |
| victim_way | output | WAY_W | Replacement candidate for `query_set` |
| set_ages | output | NUM_WAYS*AGE_W | Counters of `query_set`, way i at [i*AGE_W +: AGE_W] |

## Verification
The bench aims at the cases where the two decrement rules differ:

- A hit on a way whose counter is zero. This must age every other nonzero way, like a fill does. A design that compared with the wrong operator would leave those ways untouched.
- A hit on a way already at maximum. This must leave the rest alone. A design that used the fill rule here would wrongly age them.
- Ties between equal minimum counters. These must go to the lowest way. A design that scanned from the top, or used a non-strict compare, would name a higher way.
- Invalidations, and events aimed at a different set than the one observed. These expose a design that clears or ages the wrong row.

A long pseudo-random event stream is compared against a reference model after every event.

// File: rtl/lru_pkg.sv
package lru_pkg;

    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_HIT  = 2'd1,
        EVT_FILL = 2'd2,
        EVT_INV  = 2'd3
    } evt_kind_e;

endpackage

// File: rtl/lru_age_update.sv
module lru_age_update
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int USTATES  = 4,
    localparam int AGE_W   = $clog2(USTATES),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  evt_kind_e                          kind,
    input  logic [WAY_W-1:0]                   way,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]     age_i,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]     age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(USTATES - 1);

    logic [AGE_W-1:0] ref_age;

    always_comb begin
        ref_age = age_i[way];
        for (int i = 0; i < NUM_WAYS; i++) begin
            age_o[i] = age_i[i];
            unique case (kind)
                EVT_HIT: begin
                    if (WAY_W'(i) == way)
                        age_o[i] = AGE_MAX;
                    else if (age_i[i] > ref_age)
                        age_o[i] = age_i[i] - 1'b1;
                end
                EVT_FILL: begin
                    if (WAY_W'(i) == way)
                        age_o[i] = AGE_MAX;
                    else if (age_i[i] != '0)
                        age_o[i] = age_i[i] - 1'b1;
                end
                EVT_INV: begin
                    if (WAY_W'(i) == way)
                        age_o[i] = '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
    parameter int NUM_WAYS = 4,
    parameter int USTATES  = 4,
    localparam int AGE_W   = $clog2(USTATES),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][AGE_W-1:0] age_i,
    output logic [WAY_W-1:0]               victim
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(USTATES - 1);

    logic [AGE_W-1:0] min_age;

    // strict compare keeps the lowest index on ties; default way 0
    always_comb begin
        min_age = AGE_MAX;
        victim  = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (age_i[i] < min_age) begin
                min_age = age_i[i];
                victim  = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/lru_sat_repl.sv
module lru_sat_repl
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int USTATES  = 4,
    localparam int AGE_W   = $clog2(USTATES),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit_en,
    input  logic                      fill_en,
    input  logic                      inv_en,
    input  logic [SET_W-1:0]          evt_set,
    input  logic [WAY_W-1:0]          evt_way,
    input  logic [SET_W-1:0]          query_set,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS*AGE_W-1:0] set_ages
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(USTATES - 1);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] age;
    } state_t;

    state_t    state_d, state_q;
    evt_kind_e kind;
    logic [NUM_WAYS-1:0][AGE_W-1:0] evt_row, upd_row, q_row;

    // fill > hit > invalidate when the protocol is broken
    always_comb begin
        if (fill_en)     kind = EVT_FILL;
        else if (hit_en) kind = EVT_HIT;
        else if (inv_en) kind = EVT_INV;
        else             kind = EVT_NONE;
    end

    assign evt_row = state_q.age[evt_set];
    assign q_row   = state_q.age[query_set];

    lru_age_update #(.NUM_WAYS(NUM_WAYS), .USTATES(USTATES)) u_update (
        .kind  (kind),
        .way   (evt_way),
        .age_i (evt_row),
        .age_o (upd_row)
    );

    lru_victim_sel #(.NUM_WAYS(NUM_WAYS), .USTATES(USTATES)) u_victim (
        .age_i  (q_row),
        .victim (victim_way)
    );

    always_comb begin
        state_d = state_q;
        if (kind != EVT_NONE)
            state_d.age[evt_set] = upd_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign set_ages = q_row;

    // ---------------- assertions ----------------
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit_en, fill_en, inv_en}) <= 1); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_en || fill_en || inv_en) |=> $stable(state_q)); // R8

    AST_FILL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> state_q.age[$past(evt_set)][$past(evt_way)] == AGE_MAX); // R3

    AST_HIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !fill_en) |=> state_q.age[$past(evt_set)][$past(evt_way)] == AGE_MAX); // R2

    AST_INV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !hit_en && !fill_en) |=> state_q.age[$past(evt_set)][$past(evt_way)] == '0); // R6

    for (genvar gi = 0; gi < NUM_WAYS; gi++) begin : g_chk
        AST_AGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            q_row[gi] <= AGE_MAX); // R5
        AST_VICTIM_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            q_row[victim_way] <= q_row[gi]); // R4
        AST_VICTIM_TIE: assert property (@(posedge clk) disable iff (!rst_n)
            (q_row[gi] == q_row[victim_way] && q_row[gi] != AGE_MAX)
                |-> (WAY_W'(gi) >= victim_way)); // R4
    end

endmodule

// File: tb/lru_sat_repl_bench.sv
module lru_sat_repl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 16;
    localparam int NW  = 4;
    localparam int US  = 4;
    localparam int AW  = $clog2(US);
    localparam int WW  = $clog2(NW);
    localparam int SW  = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_en = 1'b0, fill_en = 1'b0, inv_en = 1'b0;
    logic [SW-1:0] evt_set = '0, query_set = '0;
    logic [WW-1:0] evt_way = '0;
    logic [WW-1:0] victim_way;
    logic [NW*AW-1:0] set_ages;

    always #(CLK_PERIOD/2) clk = ~clk;

    lru_sat_repl #(.NUM_SETS(NS), .NUM_WAYS(NW), .USTATES(US)) u_lru_sat_repl (
        .clk, .rst_n, .hit_en, .fill_en, .inv_en,
        .evt_set, .evt_way, .query_set, .victim_way, .set_ages
    );

    typedef struct {
        logic [NW*AW-1:0] ages;
        logic [WW-1:0]    victim;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    int   mdl [NS][NW];
    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;

    function automatic logic [NW*AW-1:0] pack_row(int s);
        logic [NW*AW-1:0] r;
        for (int i = 0; i < NW; i++) r[i*AW +: AW] = AW'(mdl[s][i]);
        return r;
    endfunction

    function automatic logic [WW-1:0] pick(int s);
        int m, v;
        m = US - 1; v = 0;
        for (int i = 0; i < NW; i++)
            if (mdl[s][i] < m) begin m = mdl[s][i]; v = i; end
        return WW'(v);
    endfunction

    // kind: 0 idle, 1 hit, 2 fill, 3 inv
    task automatic apply_model(int kind, int s, int w);
        int r;
        r = mdl[s][w];
        for (int i = 0; i < NW; i++) begin
            if (i == w) continue;
            if (kind == 1 && mdl[s][i] > r) mdl[s][i]--;
            if (kind == 2 && mdl[s][i] != 0) mdl[s][i]--;
        end
        if (kind == 1 || kind == 2) mdl[s][w] = US - 1;
        if (kind == 3) mdl[s][w] = 0;
    endtask

    task automatic drive(int kind, int s, int w, int qs, string req);
        exp_t e;
        @(posedge clk); #1;
        hit_en = (kind == 1); fill_en = (kind == 2); inv_en = (kind == 3);
        evt_set = SW'(s); evt_way = WW'(w); query_set = SW'(qs);
        apply_model(kind, s, w);
        @(posedge clk); #1;
        hit_en = 0; fill_en = 0; inv_en = 0;
        e.ages = pack_row(qs); e.victim = pick(qs); e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_cmp++;
                if (set_ages !== e.ages || victim_way !== e.victim) begin
                    n_bad++;
                    $display("FAIL %s: ages=%h victim=%0d expected ages=%h victim=%0d",
                             e.req, set_ages, victim_way, e.ages, e.victim);
                end
            end
        end
    end

    initial begin
        int seed, k, s, w, q;
        for (int i = 0; i < NS; i++) for (int j = 0; j < NW; j++) mdl[i][j] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R8 idle hold
        drive(0, 0, 0, 0, "R1");
        drive(0, 0, 0, 9, "R1");
        // R3 fills build ages 0,1,2,3
        drive(2, 3, 0, 3, "R3");
        drive(2, 3, 1, 3, "R3");
        drive(2, 3, 2, 3, "R3");
        drive(2, 3, 3, 3, "R3");
        // R2 mid hit, then hit on zero-aged way
        drive(1, 3, 1, 3, "R2");
        drive(1, 3, 0, 3, "R2");
        // R2 hit on a way already at max leaves the others
        drive(1, 3, 0, 3, "R2");
        // R6 invalidate; R4 tie on two zeros picks lower way
        drive(3, 3, 1, 3, "R6");
        drive(0, 0, 0, 3, "R4");
        // R7 events on set 7 leave set 3 alone
        drive(2, 7, 2, 3, "R7");
        drive(1, 7, 2, 3, "R7");
        drive(3, 7, 0, 3, "R7");
        drive(0, 0, 0, 7, "R7");
        // R8 idle hold
        drive(0, 0, 0, 3, "R8");
        // R5 / R9 mixed pseudo-random stream
        seed = 32'h1bad5eed;
        for (int n = 0; n < 400; n++) begin
            seed = seed * 1103515245 + 12345;
            k = (seed >>> 8) & 3;
            s = (seed >>> 12) & 3;
            w = (seed >>> 16) & (NW - 1);
            q = ((seed >>> 20) & 7) == 0 ? ((seed >>> 24) & 3) : s;
            drive(k, s, w, q, k == 1 ? "R2" : k == 2 ? "R3" : k == 3 ? "R6" : "R9");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule